// File: doc/BRIEF.md
# Range-Protected Write-Allocate Filter

This block decides, for every pending write to a 32-bit physical address, whether the cache may fill the addressed line and merge the write into it. It does not forward the write to the bus. Allocation is allowed only when a global switch is on and the address falls in none of three exclusion windows. Each window has its own enable bit.

The first window is a fixed low-memory region that holds display memory and boot ROM. The second is a programmable hole for memory-mapped adapters. Its bounds have a granularity of 64 KB. The third covers everything above a programmable top-of-memory bound. The cache controller presents the write address and reads `alloc_ok` in the same cycle.

Three registers hold the settings: a configuration word, a limit-and-control word and a range word. They are written and read through a small select/write-enable port, and there is no handshake on that port. The reset input is asserted asynchronously and released synchronously inside the block. The registers reach their reset values while reset is asserted and stay there for two clocks after it is released.

Top module: `wa_alloc_filter`

## Requirements
- R1: After reset every register reads back 0 and `alloc_ok` is 0.
- R2: The global allocate switch is configuration-word bit 4 (select 0). While it is 0, `alloc_ok` is 0 for every address.
- R3: When control-word bit 16 is 1, addresses 0x000A0000 through 0x000FFFFF are not allocatable. The bounds are inclusive.
- R4: The range word (select 2) holds a low page in bits 15:0 and a high page in bits 31:16. When control-word bit 17 is 1, addresses from {low,16'h0000} through {high,16'hFFFF} inclusive are not allocatable.
- R5: Control-word bits 15:0 give the top-of-memory page. When control-word bit 18 is 1, addresses strictly greater than {page,16'h0000} are not allocatable, and an address equal to it stays allocatable. Page 0x0100 places the bound at 16 MB.
- R6: A window whose enable bit is 0 has no effect. With the global switch on and all enables off, every address is allocatable.
- R7: Reserved bits read back as 0 and ignore writes. In the configuration word every bit except bit 4 is reserved. In the control word bits 31:19 are reserved.
- R8: `alloc_ok` follows `wr_addr` combinationally within the cycle. A register write takes effect on `alloc_ok` and `reg_rdata` after the clock edge that samples it.
- R9: `reg_sel` encodes 0 = configuration, 1 = control, 2 = range. Select 3 reads as 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| wr_addr | input | 32 | Physical address of the pending write |
| alloc_ok | output | 1 | High when the write may be allocated |

## Verification
The assertions assume that `reg_we`, `reg_sel`, `reg_wdata` and `wr_addr` carry known values at every rising edge once reset has been released. They also assume that register writes issued during the two synchronizer cycles are meant to be lost. The bench drives every input on the falling edge and never leaves one undriven. It waits for the synchronized reset to release before its first write, and it reads outputs one nanosecond after a falling edge, before the next rising edge.

// File: rtl/wa_filter_pkg.sv
package wa_filter_pkg;
  localparam int ADDR_W   = 32;
  localparam int OFS_W    = 16;
  localparam int PG_W     = ADDR_W - OFS_W;
  localparam int NUM_WIN  = 3;
  localparam int EN_BIT   = 4;
  localparam int WIN_BASE = 16;

  // Window order matches control-word enable bit order (base + index).
  localparam int WIN_FIX = 0;
  localparam int WIN_PRG = 1;
  localparam int WIN_TOM = 2;

  localparam logic [ADDR_W-1:0] CFG_MASK = ADDR_W'(1) << EN_BIT;
  localparam logic [ADDR_W-1:0] CTL_MASK =
    (ADDR_W'((1 << NUM_WIN) - 1) << WIN_BASE) | ADDR_W'((1 << PG_W) - 1);

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_RNG  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef logic [PG_W-1:0]   page_t;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/wa_regfile.sv
module wa_regfile
  import wa_filter_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [1:0]         sel,
  input  logic [ADDR_W-1:0]  wdata,
  output logic [ADDR_W-1:0]  rdata,
  output logic               gen_en,
  output page_t              tom_pg,
  output logic [NUM_WIN-1:0] win_en,
  output page_t              rng_lo,
  output page_t              rng_hi
);
  reg_sel_e sel_e;
  assign sel_e = reg_sel_e'(sel);

  // Only defined bits are stored; reserved bits have no flops.
  logic               en_q,  en_d;
  page_t              tom_q, tom_d;
  logic [NUM_WIN-1:0] wen_q, wen_d;
  page_t              lo_q,  lo_d;
  page_t              hi_q,  hi_d;
  logic               cfg_ld, ctl_ld, rng_ld;

  // Next-state and load enables
  always_comb begin
    cfg_ld = we && (sel_e == SEL_CFG);
    ctl_ld = we && (sel_e == SEL_CTL);
    rng_ld = we && (sel_e == SEL_RNG);
    en_d   = wdata[EN_BIT];
    tom_d  = wdata[PG_W-1:0];
    wen_d  = wdata[WIN_BASE +: NUM_WIN];
    lo_d   = wdata[PG_W-1:0];
    hi_d   = wdata[2*PG_W-1:PG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (cfg_ld) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tom_q <= '0;
      wen_q <= '0;
    end else if (ctl_ld) begin
      tom_q <= tom_d;
      wen_q <= wen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (rng_ld) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  // Read mux; unused positions read as zero.
  always_comb begin
    rdata = '0;
    case (sel_e)
      SEL_CFG: rdata[EN_BIT] = en_q;
      SEL_CTL: begin
        rdata[PG_W-1:0]            = tom_q;
        rdata[WIN_BASE +: NUM_WIN] = wen_q;
      end
      SEL_RNG: rdata = {hi_q, lo_q};
      default: rdata = '0;
    endcase
  end

  assign gen_en = en_q;
  assign tom_pg = tom_q;
  assign win_en = wen_q;
  assign rng_lo = lo_q;
  assign rng_hi = hi_q;
endmodule

// File: rtl/wa_window.sv
module wa_window
  import wa_filter_pkg::*;
(
  input  logic  en,
  input  addr_t addr,
  input  addr_t lo,
  input  addr_t hi,
  output logic  hit
);
  // Inclusive window; empty when lo > hi.
  assign hit = en && (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/wa_alloc_filter.sv
module wa_alloc_filter
  import wa_filter_pkg::*;
#(
  parameter addr_t FIX_LO = 32'h000A_0000,
  parameter addr_t FIX_HI = 32'h000F_FFFF
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              alloc_ok
);
  // Asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  logic               gen_en;
  page_t              tom_pg;
  logic [NUM_WIN-1:0] win_en;
  page_t              rng_lo;
  page_t              rng_hi;

  wa_regfile u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (reg_we),
    .sel    (reg_sel),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .gen_en (gen_en),
    .tom_pg (tom_pg),
    .win_en (win_en),
    .rng_lo (rng_lo),
    .rng_hi (rng_hi)
  );

  // Window bounds. "Above top" is rewritten as an inclusive window that
  // starts one byte past the bound; the low offset bits are zero, so the
  // increment cannot wrap.
  addr_t [NUM_WIN-1:0] win_lo;
  addr_t [NUM_WIN-1:0] win_hi;

  always_comb begin
    win_lo[WIN_FIX] = FIX_LO;
    win_hi[WIN_FIX] = FIX_HI;
    win_lo[WIN_PRG] = {rng_lo, {OFS_W{1'b0}}};
    win_hi[WIN_PRG] = {rng_hi, {OFS_W{1'b1}}};
    win_lo[WIN_TOM] = {tom_pg, {OFS_W{1'b0}}} + ADDR_W'(1);
    win_hi[WIN_TOM] = {ADDR_W{1'b1}};
  end

  logic [NUM_WIN-1:0] win_hit;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    wa_window u_win (
      .en   (win_en[g]),
      .addr (wr_addr),
      .lo   (win_lo[g]),
      .hi   (win_hi[g]),
      .hit  (win_hit[g])
    );
  end

  assign alloc_ok = gen_en && !(|win_hit);
endmodule

// File: rtl/wa_alloc_filter_chk.sv
module wa_alloc_filter_chk
  import wa_filter_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               reg_we,
  input logic [1:0]         reg_sel,
  input logic [ADDR_W-1:0]  reg_wdata,
  input logic [ADDR_W-1:0]  reg_rdata,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic               alloc_ok,
  input logic               gen_en,
  input page_t              tom_pg,
  input logic [NUM_WIN-1:0] win_en,
  input page_t              rng_lo,
  input page_t              rng_hi
);
  assert_global_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |-> !alloc_ok);

  assert_fixed_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en[WIN_FIX] && wr_addr >= 32'h000A_0000 && wr_addr <= 32'h000F_FFFF)
      |-> !alloc_ok);

  assert_prog_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en[WIN_PRG] && wr_addr[ADDR_W-1:OFS_W] >= rng_lo &&
     wr_addr[ADDR_W-1:OFS_W] <= rng_hi) |-> !alloc_ok);

  assert_tom_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en[WIN_TOM] && wr_addr > {tom_pg, {OFS_W{1'b0}}}) |-> !alloc_ok);

  assert_no_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && win_en == '0) |-> alloc_ok);

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_sel == 2'd0) |-> ((reg_rdata & ~CFG_MASK) == '0)) and
    ((reg_sel == 2'd1) |-> ((reg_rdata & ~CTL_MASK) == '0)));

  assert_ctl_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_we) && $past(reg_sel) == 2'd1)
      |-> ({13'd0, win_en, tom_pg} == ($past(reg_wdata) & CTL_MASK)));

  assert_sel3_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd3)
      |=> ($stable(gen_en) && $stable(tom_pg) && $stable(win_en) &&
           $stable(rng_lo) && $stable(rng_hi)));

  assert_sel3_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd3) |-> (reg_rdata == '0));
endmodule

bind wa_alloc_filter wa_alloc_filter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .wr_addr   (wr_addr),
  .alloc_ok  (alloc_ok),
  .gen_en    (gen_en),
  .tom_pg    (tom_pg),
  .win_en    (win_en),
  .rng_lo    (rng_lo),
  .rng_hi    (rng_hi)
);

// File: tb/sim_wa_alloc_filter.sv
`timescale 1ns/1ps
module sim_wa_alloc_filter;
  logic        clk;
  logic        rst_ni;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [31:0] wr_addr;
  logic        alloc_ok;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  wa_alloc_filter u0 (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .wr_addr   (wr_addr),
    .alloc_ok  (alloc_ok)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_sel = sel;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic probe(input logic [31:0] addr, input logic exp, input string req);
    @(negedge clk);
    wr_addr = addr;
    #1;
    chk(req, {31'd0, alloc_ok}, {31'd0, exp});
  endtask

  task automatic t_reset;
    rd(2'd0, 32'h0, "R1 cfg");
    rd(2'd1, 32'h0, "R1 ctl");
    rd(2'd2, 32'h0, "R1 rng");
    probe(32'h0000_1000, 1'b0, "R1 alloc_ok");
    probe(32'h0000_1000, 1'b0, "R2 switch off");
  endtask

  task automatic t_reserved;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 32'h0000_0010, "R7 cfg reserved");
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h0007_FFFF, "R7 ctl reserved");
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, 32'hFFFF_FFFF, "R4 rng full");
    wr(2'd1, 32'h0);
    wr(2'd0, 32'hFFFF_FFEF);
    rd(2'd0, 32'h0, "R7 cfg only bit4");
    probe(32'h0000_1000, 1'b0, "R2 bit4 cleared");
  endtask

  task automatic t_no_windows;
    wr(2'd0, 32'h0000_0010);
    wr(2'd1, 32'h0000_0000);
    probe(32'h0000_0000, 1'b1, "R6 addr 0");
    probe(32'h000B_8000, 1'b1, "R6 fixed off");
    probe(32'hFFFF_FFFF, 1'b1, "R6 top off");
  endtask

  task automatic t_fixed;
    wr(2'd1, 32'h0001_0000);
    probe(32'h0009_FFFF, 1'b1, "R3 below");
    probe(32'h000A_0000, 1'b0, "R3 low edge");
    probe(32'h000F_FFFF, 1'b0, "R3 high edge");
    probe(32'h0010_0000, 1'b1, "R3 above");
  endtask

  task automatic t_prog;
    wr(2'd2, 32'h00FF_00F0);
    rd(2'd2, 32'h00FF_00F0, "R4 readback");
    wr(2'd1, 32'h0002_0000);
    probe(32'h000B_0000, 1'b1, "R6 fixed disabled");
    probe(32'h00EF_FFFF, 1'b1, "R4 below");
    probe(32'h00F0_0000, 1'b0, "R4 low edge");
    probe(32'h00FF_FFFF, 1'b0, "R4 high edge");
    probe(32'h0100_0000, 1'b1, "R4 above");
  endtask

  task automatic t_tom;
    wr(2'd1, 32'h0004_0100);
    probe(32'h00FF_FFFF, 1'b1, "R5 below");
    probe(32'h0100_0000, 1'b1, "R5 equal");
    probe(32'h0100_0001, 1'b0, "R5 above");
    probe(32'hFFFF_FFFF, 1'b0, "R5 top");
    probe(32'h00F8_0000, 1'b1, "R6 prog disabled");
  endtask

  task automatic t_all;
    wr(2'd1, 32'h0007_0200);
    probe(32'h000B_0000, 1'b0, "R3 all on");
    probe(32'h00F8_0000, 1'b0, "R4 all on");
    probe(32'h0200_0001, 1'b0, "R5 all on");
    probe(32'h0180_0000, 1'b1, "R5 inside ram");
    probe(32'h0020_0000, 1'b1, "R6 gap");
    wr(2'd0, 32'h0);
    probe(32'h0020_0000, 1'b0, "R2 master off");
  endtask

  task automatic t_sel3;
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, 32'h0, "R9 sel3 read");
    rd(2'd0, 32'h0, "R9 cfg kept");
    rd(2'd1, 32'h0007_0200, "R9 ctl kept");
    rd(2'd2, 32'h00FF_00F0, "R9 rng kept");
  endtask

  task automatic t_timing;
    wr(2'd1, 32'h0004_0100);
    @(negedge clk);
    wr_addr = 32'h0020_0000;
    reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h0000_0010;
    #1;
    chk("R8 before edge", {31'd0, alloc_ok}, 32'd0);
    @(posedge clk);
    #1;
    chk("R8 after edge", {31'd0, alloc_ok}, 32'd1);
    @(negedge clk);
    reg_we = 1'b0;
    wr_addr = 32'h0100_0000;
    #1;
    chk("R8 comb equal", {31'd0, alloc_ok}, 32'd1);
    wr_addr = 32'h0100_0001;
    #1;
    chk("R8 comb above", {31'd0, alloc_ok}, 32'd0);
  endtask

  initial begin
    rst_ni = 1'b0; reg_we = 1'b0; reg_sel = 2'd0;
    reg_wdata = 32'h0; wr_addr = 32'h0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_reserved();
    t_no_windows();
    t_fixed();
    t_prog();
    t_tom();
    t_all();
    t_sel3();
    t_timing();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule